// File: doc/BRIEF.md
# UART Channel Clock Source Router

This block holds one byte of clock routing configuration for a single UART channel and steers timing enables to the channel's receiver, transmitter and modem-control output. The receiver and transmitter each get a one-cycle tick plus a flag that tells the downstream sampler whether to oversample (Nx mode) or to take one sample per bit (isochronous 1x mode). The tick can come from the baud generator, from an external pin clock, or, for the receiver, from whatever clock the transmitter is using.

External pin clocks are resynchronised into the system clock domain and edge-detected, so every tick that leaves the block is a single-cycle enable in the system clock domain. The register is cleared only by the hardware reset. The software reset leaves it unchanged, so software can pick a clock source first and then reset the channel to clear out any disturbance caused by the switch. The DTR output can carry its normal modem-control value, the transmit bit clock, or the baud generator's Nx clock.

Top module: `uart_clk_route`

## Requirements
- R1: While `hwRstN` is low at a clock edge, the register is cleared to 0x00. Reset state: receiver and transmitter both take `baudTick`, both mode flags are 0 (Nx), and `dtrOut` follows `modemDtr`.
- R2: `swRst` has no effect on the register or on any output. A write in the same cycle as `swRst` still takes effect.
- R3: A write with `cfgWrEn` high updates the register at the next clock edge. `cfgRdData` returns the register, and bit 2 always reads 0 whatever was written to it.
- R4: Bits [1:0] select the receive tick. 00 and 10 select `baudTick`, and 01 selects the synchronized rising-edge enable of `dsrClkPin`.
- R5: `rxIs1x` equals register bit 3. A value of 1 means isochronous 1x and 0 means Nx.
- R6: Bit 6 selects the transmit tick. 0 selects `baudTick` and 1 selects the synchronized rising-edge enable of `riClkPin`.
- R7: `txIs1x` equals register bit 7.
- R8: Bits [5:4] select `dtrOut`. 00 selects `modemDtr`, 01 selects `txBitTick`, 10 selects `baudTick`, and the reserved code 11 behaves like 00.
- R9: Each pin clock passes through a two-flop synchronizer and a rising-edge detector. For a pin sampled low at edge n-2 and high at edge n-1, the enable is high for exactly the cycle after edge n. A pin held high gives only one pulse.
- R10: Receive code 11 makes `rxTick` equal to `txTick` in every cycle, including when the transmitter runs from `riClkPin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| hwRstN | input | 1 | Hardware reset, active low, synchronous |
| swRst | input | 1 | Channel software reset; does not touch this block |
| cfgWrEn | input | 1 | Register write strobe |
| cfgWrData | input | 8 | Register write data |
| cfgRdData | output | 8 | Register read value |
| baudTick | input | 1 | Nx enable from the baud generator |
| txBitTick | input | 1 | Once-per-bit enable from the transmitter |
| dsrClkPin | input | 1 | External receive clock pin, asynchronous |
| riClkPin | input | 1 | External transmit clock pin, asynchronous |
| modemDtr | input | 1 | Normal modem-control DTR value |
| rxTick | output | 1 | Receive sampling enable |
| rxIs1x | output | 1 | Receive mode flag, 1 means 1x |
| txTick | output | 1 | Transmit enable |
| txIs1x | output | 1 | Transmit mode flag, 1 means 1x |
| dtrOut | output | 1 | Value driven on the DTR pin |

## Verification
Two functions can fall in the same cycle. A register write can meet a software reset, and a routing change can land on the same edge that an external pin edge reaches the end of its synchronizer. The bench provokes both on purpose. It writes every one of the 256 byte values while pulsing `swRst` on alternate writes, and it keeps both pin clocks toggling and the ticks random while the writes happen. A behavioural model built from pin-sample queues and the requirement tables predicts every output in every cycle, and each output is compared against that prediction before the next clock edge.

// File: rtl/uart_clk_route_pkg.sv
package uart_clk_route_pkg;

  localparam int CFG_W = 8;

  typedef enum logic [1:0] {
    RX_BAUD     = 2'b00,
    RX_DSR_PIN  = 2'b01,
    RX_BAUD_ALT = 2'b10,
    RX_FROM_TX  = 2'b11
  } rxSrc_e;

  typedef enum logic [1:0] {
    DTR_MODEM = 2'b00,
    DTR_TXBIT = 2'b01,
    DTR_BAUD  = 2'b10,
    DTR_RSVD  = 2'b11
  } dtrSel_e;

  typedef struct packed {
    rxSrc_e  rxSrc;
    logic    rxIs1x;
    logic    txFromPin;
    logic    txIs1x;
    dtrSel_e dtrSel;
  } routeCtl_t;

endpackage

// File: rtl/uart_clk_pin_sync.sv
module uart_clk_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic hwRstN,
  input  logic pinIn,
  output logic riseEn
);
  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk) begin
    if (!hwRstN) chain <= '0;
    else         chain <= {chain[CHAIN_W-2:0], pinIn};
  end

  assign riseEn = chain[STAGES-1] & ~chain[STAGES];

  // R9: a rising edge yields a single-cycle enable
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!hwRstN)
    riseEn |=> !riseEn);

endmodule

// File: rtl/uart_clk_route_ctl.sv
module uart_clk_route_ctl
  import uart_clk_route_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESV_MASK = 8'h04
) (
  input  logic             clk,
  input  logic             hwRstN,
  input  logic             swRst,
  input  logic             wrEn,
  input  logic [CFG_W-1:0] wrData,
  output logic [CFG_W-1:0] rdData,
  output routeCtl_t        ctl
);
  localparam int BIT_RX1X  = 3;
  localparam int BIT_TXPIN = 6;
  localparam int BIT_TX1X  = 7;

  logic [CFG_W-1:0] cfgReg;

  always_ff @(posedge clk) begin
    if (!hwRstN)   cfgReg <= '0;
    else if (wrEn) cfgReg <= wrData & ~RESV_MASK;
  end

  assign rdData = cfgReg;

  always_comb begin
    ctl.rxSrc     = rxSrc_e'(cfgReg[1:0]);
    ctl.rxIs1x    = cfgReg[BIT_RX1X];
    ctl.dtrSel    = dtrSel_e'(cfgReg[5:4]);
    ctl.txFromPin = cfgReg[BIT_TXPIN];
    ctl.txIs1x    = cfgReg[BIT_TX1X];
  end

  // R1: register is zero on the first cycle out of hardware reset
  assert_hw_clear_R1: assert property (@(posedge clk) disable iff (!hwRstN)
    $rose(hwRstN) |-> cfgReg == '0);

  // R2: software reset without a write leaves the register alone
  assert_sw_keep_R2: assert property (@(posedge clk) disable iff (!hwRstN)
    (swRst && !wrEn) |=> $stable(cfgReg));

endmodule

// File: rtl/uart_clk_route_dp.sv
module uart_clk_route_dp
  import uart_clk_route_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      hwRstN,
  input  routeCtl_t ctl,
  input  logic      baudTick,
  input  logic      txBitTick,
  input  logic      dsrClkPin,
  input  logic      riClkPin,
  input  logic      modemDtr,
  output logic      rxTick,
  output logic      rxIs1x,
  output logic      txTick,
  output logic      txIs1x,
  output logic      dtrOut
);
  localparam int NUM_PINS = 2;
  localparam int PIN_DSR  = 0;
  localparam int PIN_RI   = 1;

  logic [NUM_PINS-1:0] pinVec;
  logic [NUM_PINS-1:0] edgeVec;

  assign pinVec[PIN_DSR] = dsrClkPin;
  assign pinVec[PIN_RI]  = riClkPin;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    uart_clk_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .hwRstN (hwRstN),
      .pinIn  (pinVec[p]),
      .riseEn (edgeVec[p])
    );
  end

  assign txTick = ctl.txFromPin ? edgeVec[PIN_RI] : baudTick;
  assign txIs1x = ctl.txIs1x;
  assign rxIs1x = ctl.rxIs1x;

  always_comb begin
    unique case (ctl.rxSrc)
      RX_DSR_PIN: rxTick = edgeVec[PIN_DSR];
      RX_FROM_TX: rxTick = txTick;
      default:    rxTick = baudTick;
    endcase
  end

  always_comb begin
    unique case (ctl.dtrSel)
      DTR_TXBIT: dtrOut = txBitTick;
      DTR_BAUD:  dtrOut = baudTick;
      default:   dtrOut = modemDtr;
    endcase
  end

  // R10: loop-back code keeps receiver on the transmit clock
  assert_rx_loop_R10: assert property (@(posedge clk) disable iff (!hwRstN)
    (ctl.rxSrc == RX_FROM_TX) |-> (rxTick == txTick));

endmodule

// File: rtl/uart_clk_route.sv
module uart_clk_route
  import uart_clk_route_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             hwRstN,
  input  logic             swRst,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [CFG_W-1:0] cfgRdData,
  input  logic             baudTick,
  input  logic             txBitTick,
  input  logic             dsrClkPin,
  input  logic             riClkPin,
  input  logic             modemDtr,
  output logic             rxTick,
  output logic             rxIs1x,
  output logic             txTick,
  output logic             txIs1x,
  output logic             dtrOut
);
  routeCtl_t routeCtl;

  uart_clk_route_ctl u_ctl (
    .clk    (clk),
    .hwRstN (hwRstN),
    .swRst  (swRst),
    .wrEn   (cfgWrEn),
    .wrData (cfgWrData),
    .rdData (cfgRdData),
    .ctl    (routeCtl)
  );

  uart_clk_route_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .hwRstN    (hwRstN),
    .ctl       (routeCtl),
    .baudTick  (baudTick),
    .txBitTick (txBitTick),
    .dsrClkPin (dsrClkPin),
    .riClkPin  (riClkPin),
    .modemDtr  (modemDtr),
    .rxTick    (rxTick),
    .rxIs1x    (rxIs1x),
    .txTick    (txTick),
    .txIs1x    (txIs1x),
    .dtrOut    (dtrOut)
  );

endmodule

// File: tb/uart_clk_route_bench.sv
module uart_clk_route_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       hwRstN = 1'b0, swRst = 1'b0, cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = 8'h00;
  logic       baudTick = 1'b0, txBitTick = 1'b0, dsrClkPin = 1'b0, riClkPin = 1'b0, modemDtr = 1'b0;
  logic [7:0] cfgRdData;
  logic       rxTick, rxIs1x, txTick, txIs1x, dtrOut;

  uart_clk_route u_uart_clk_route (
    .clk(clk), .hwRstN(hwRstN), .swRst(swRst), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .baudTick(baudTick),
    .txBitTick(txBitTick), .dsrClkPin(dsrClkPin), .riClkPin(riClkPin),
    .modemDtr(modemDtr), .rxTick(rxTick), .rxIs1x(rxIs1x), .txTick(txTick),
    .txIs1x(txIs1x), .dtrOut(dtrOut)
  );

  int total = 0, bad = 0;
  logic [7:0] mCfg = 8'h00;
  bit dsrQ[$] = '{0, 0, 0};
  bit riQ[$]  = '{0, 0, 0};
  logic [15:0] lf = 16'hACE1;
  int cycNum = 0;
  bit pinHold = 0;
  bit pinVal = 0;
  int rxPulses = 0;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycNum);
    end
  endtask

  task automatic compareAll();
    bit dsrRise, riRise, expTx, expRx, expDtr;
    dsrRise = dsrQ[1] && !dsrQ[2];
    riRise  = riQ[1] && !riQ[2];
    expTx   = mCfg[6] ? riRise : baudTick;
    case (mCfg[1:0])
      2'b01:   expRx = dsrRise;
      2'b11:   expRx = expTx;
      default: expRx = baudTick;
    endcase
    case (mCfg[5:4])
      2'b01:   expDtr = txBitTick;
      2'b10:   expDtr = baudTick;
      default: expDtr = modemDtr;
    endcase
    check("R3 readback", cfgRdData, mCfg);
    if (mCfg[1:0] == 2'b11)      check("R10 rx follows tx", {7'd0, rxTick}, {7'd0, expRx});
    else if (mCfg[1:0] == 2'b01) check("R9 rx dsr pin", {7'd0, rxTick}, {7'd0, expRx});
    else                         check("R4 rx baud", {7'd0, rxTick}, {7'd0, expRx});
    check("R5 rx mode", {7'd0, rxIs1x}, {7'd0, mCfg[3]});
    check("R6 tx tick", {7'd0, txTick}, {7'd0, expTx});
    check("R7 tx mode", {7'd0, txIs1x}, {7'd0, mCfg[7]});
    check("R8 dtr", {7'd0, dtrOut}, {7'd0, expDtr});
    if (rxTick === 1'b1) rxPulses++;
  endtask

  task automatic modelEdge();
    if (!hwRstN) begin
      mCfg = 8'h00;
      dsrQ = '{0, 0, 0};
      riQ  = '{0, 0, 0};
    end else begin
      if (cfgWrEn) mCfg = cfgWrData & 8'hFB;
      dsrQ.push_front(dsrClkPin); void'(dsrQ.pop_back());
      riQ.push_front(riClkPin);   void'(riQ.pop_back());
    end
  endtask

  task automatic cyc(bit rstN, bit sw, bit we, logic [7:0] d);
    @(negedge clk);
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    hwRstN = rstN; swRst = sw; cfgWrEn = we; cfgWrData = d;
    baudTick = lf[0]; txBitTick = lf[5]; modemDtr = lf[9];
    dsrClkPin = pinHold ? pinVal : cycNum[2];
    riClkPin  = cycNum[1];
    #5 compareAll();
    @(posedge clk);
    #1 modelEdge();
    cycNum++;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) cyc(0, 0, 0, 8'h00);
    #2 check("R1 cleared after reset", cfgRdData, 8'h00);

    for (int v = 0; v < 256; v++) begin
      cyc(1, v[0], 1, v[7:0]);
      for (int k = 0; k < 12; k++) cyc(1, lf[3], 0, 8'h00);
    end

    cyc(1, 1, 1, 8'hC5);
    for (int k = 0; k < 6; k++) cyc(1, 1, 0, 8'h00);
    #2 check("R2 kept across sw reset", cfgRdData, 8'hC1);
    check("R3 bit2 reads zero", {7'd0, cfgRdData[2]}, 8'h00);

    cyc(1, 0, 1, 8'hFF);
    cyc(0, 0, 0, 8'h00);
    #2 check("R1 cleared mid-run", cfgRdData, 8'h00);

    pinHold = 1; pinVal = 0;
    cyc(1, 0, 1, 8'h01);
    for (int k = 0; k < 4; k++) cyc(1, 0, 0, 8'h00);
    rxPulses = 0;
    pinVal = 1;
    for (int k = 0; k < 8; k++) cyc(1, 0, 0, 8'h00);
    check("R9 one pulse for held pin", rxPulses[7:0], 8'd1);
    pinHold = 0;

    summary();
    $finish;
  end
endmodule